// File: doc/BRIEF.md
# Snooping Three-State Cache Coherence Controller

This block keeps one small private write-back cache coherent with its peers on a shared snooping bus, using a three-state write-invalidate scheme. Each line is Invalid, Shared (a clean copy that others may also hold) or Modified (the only copy, and dirty). The core side takes one read or write request per cycle. The controller either completes the request at once or asks for the bus. The bus side watches the transactions of other cores. When another core wants a line this cache holds dirty, the controller supplies the data itself, in place of the shared level below.

The cache is direct-mapped with one word per line. Snoop lookups read a second, mirrored copy of the state and tag array, so a snoop to one line never delays a core access to another line. An external arbiter grants the bus. A write that loses a same-cycle race to a peer's invalidate finds its line Invalid on its next attempt, and is then reissued as a write miss.

Top module: `msi_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid: no bus request, no completion and no data supply are raised while idle, and the first access to any address needs the bus.
- R2: A read that misses on a line that is not Modified requests the bus with command 0 (read miss) and the full block address. In the granted cycle it completes with `cpu_rdata` equal to `bus_rdata`, and the line becomes Shared with that word.
- R3: A read whose tag matches a Shared or Modified line completes in the same cycle with the stored word and no bus request.
- R4: A write to a matching Shared line requests command 2 (invalidate). A write that misses on a line that is not Modified requests command 1 (write miss). Once granted, either write completes and leaves the line Modified, holding the written word.
- R5: A write to a matching Modified line completes in the same cycle with no bus request.
- R6: A miss whose index holds a Modified line with another tag first requests command 3 (write-back). This carries the old block address (old tag above the index) and the old word on `bus_wdata`. The grant leaves the line Invalid, and the miss request follows in the next cycle.
- R7: A snooped read miss (command 0) that matches a Modified line raises `snp_supply` in the same cycle with the line's word on `snp_data`, and the line drops to Shared. A later local write to it needs an invalidate.
- R8: A snooped write miss (command 1) that matches a Modified line supplies the word and invalidates the line. A snooped write miss or invalidate (command 2) that matches a Shared line invalidates it.
- R9: A snoop whose tag does not match or whose line is Invalid, a snooped write-back (command 3), and a snooped read miss to a Shared line change no state and raise no supply.
- R10: A snoop to the same index as a pending core request blocks that request for the cycle: it does not complete, requests no bus, and ignores any grant. The next cycle re-evaluates it against the post-snoop state, so a pending invalidate becomes a write miss.
- R11: A snoop to a different index does not delay a core access, which completes in the same cycle when it hits.
- R12: An ungranted bus request repeats with the same command and address while the core request is held and not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Core request present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address (tag above index) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` on a read |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 read miss, 1 write miss, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Block address of the transaction |
| bus_wdata | output | DATA_W | Word written back on command 3 |
| bus_grant | input | 1 | Arbiter grants the request this cycle |
| bus_rdata | input | DATA_W | Fill word for a granted read miss |
| snp_valid | input | 1 | Peer transaction on the bus |
| snp_cmd | input | 2 | Peer command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Peer block address |
| snp_supply | output | 1 | This cache supplies the data, overriding the shared level |
| snp_data | output | DATA_W | Supplied word |

## Verification
The two functions that can fall in the same cycle are a core request and a snoop from a peer. The bench provokes every pairing: a snoop to the same index as a pending request, and a snoop to a different index alongside a hit or a miss. It does this in directed cases and in a long pseudo-random sweep over all addresses and commands. A bench-side model of the line states and the shared level decides the outcome of each cycle. A same-index snoop must block the request and change its next command. A different-index snoop must leave a hit completing at once and hold a miss ungranted, with its command repeated.

// File: rtl/msi_pkg.sv
// Shared encodings for the snooping coherence controller.
package msi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        CMD_RDMISS = 2'd0,
        CMD_WRMISS = 2'd1,
        CMD_INVAL  = 2'd2,
        CMD_WRBACK = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/msi_tag_store.sv
// Per-line state and tag registers with one core write port and one snoop
// write port. Assumes the two ports never target the same line in a cycle;
// if they do, the snoop port wins.
module msi_tag_store #(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               lw_en,
    input  logic [IDX_W-1:0]                   lw_idx,
    input  logic [1:0]                         lw_st,
    input  logic [TAG_W-1:0]                   lw_tag,
    input  logic                               sw_en,
    input  logic [IDX_W-1:0]                   sw_idx,
    input  logic [1:0]                         sw_st,
    output logic [(1<<IDX_W)-1:0][1:0]         st_q,
    output logic [(1<<IDX_W)-1:0][TAG_W-1:0]   tag_q
);
    import msi_pkg::*;
    localparam int NLINES = 1 << IDX_W;

    // Update state and tag of each line from whichever port addresses it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NLINES; g++) begin
                st_q[g]  <= ST_I;
                tag_q[g] <= '0;
            end
        end else begin
            for (int g = 0; g < NLINES; g++) begin
                if (sw_en && sw_idx == IDX_W'(g)) begin
                    st_q[g] <= sw_st;
                end else if (lw_en && lw_idx == IDX_W'(g)) begin
                    st_q[g]  <= lw_st;
                    tag_q[g] <= lw_tag;
                end
            end
        end
    end

    // R10: the blocking rule keeps the two ports off the same line.
    a_r10_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_en && lw_en && sw_idx == lw_idx));
endmodule

// File: rtl/msi_snoop_unit.sv
// Decides the reaction of one line to a peer bus transaction: the next state
// and whether this cache supplies the data. Pure combinational logic; it
// assumes the line was read from the duplicate snoop copy of the tags.
module msi_snoop_unit #(
    parameter int TAG_W = 4
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [1:0]       line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             upd_en,
    output logic [1:0]       upd_st,
    output logic             supply
);
    import msi_pkg::*;
    logic hit;

    // Match the peer address against the line and pick the transition.
    always_comb begin
        hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
        upd_en = 1'b0;
        upd_st = line_st;
        supply = 1'b0;
        if (hit) begin
            case (bus_cmd_t'(snp_cmd))
                CMD_RDMISS: begin
                    if (line_st == ST_M) begin
                        upd_en = 1'b1;
                        upd_st = ST_S;
                        supply = 1'b1;
                    end
                end
                CMD_WRMISS: begin
                    upd_en = 1'b1;
                    upd_st = ST_I;
                    supply = (line_st == ST_M);
                end
                CMD_INVAL: begin
                    upd_en = 1'b1;
                    upd_st = ST_I;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/msi_local_unit.sv
// Decides the handling of one core request against its indexed line: finish
// now, or which bus command to request, and the line update on a grant.
// Assumes the caller blocks the request when a snoop hits the same index.
module msi_local_unit #(
    parameter int TAG_W = 4
) (
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [TAG_W-1:0] cpu_tag,
    input  logic [1:0]       line_st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic             blocked,
    input  logic             bus_grant,
    output logic             bus_need,
    output logic [1:0]       bus_cmd,
    output logic             wb_sel,
    output logic             done,
    output logic             upd_en,
    output logic [1:0]       upd_st,
    output logic [TAG_W-1:0] upd_tag,
    output logic             fill_sel,
    output logic             wr_sel
);
    import msi_pkg::*;
    logic go;
    logic hit;

    // Classify the request and derive the bus command and line update.
    always_comb begin
        go       = cpu_valid && !blocked;
        hit      = (line_st != ST_I) && (line_tag == cpu_tag);
        bus_need = 1'b0;
        bus_cmd  = CMD_RDMISS;
        wb_sel   = 1'b0;
        done     = 1'b0;
        upd_en   = 1'b0;
        upd_st   = line_st;
        fill_sel = 1'b0;
        wr_sel   = 1'b0;
        if (go) begin
            if (hit && (!cpu_write || line_st == ST_M)) begin
                done   = 1'b1;
                wr_sel = cpu_write;
            end else begin
                bus_need = 1'b1;
                if (hit) begin
                    bus_cmd = CMD_INVAL;
                end else if (line_st == ST_M) begin
                    bus_cmd = CMD_WRBACK;
                    wb_sel  = 1'b1;
                end else begin
                    bus_cmd = cpu_write ? CMD_WRMISS : CMD_RDMISS;
                end
                if (bus_grant) begin
                    upd_en = 1'b1;
                    if (wb_sel) begin
                        upd_st = ST_I;
                    end else begin
                        done     = 1'b1;
                        upd_st   = cpu_write ? ST_M : ST_S;
                        fill_sel = !cpu_write;
                        wr_sel   = cpu_write;
                    end
                end
            end
        end
        upd_tag = wb_sel ? line_tag : cpu_tag;
    end
endmodule

// File: rtl/msi_coh_ctrl.sv
// Top of the snooping three-state coherence controller for a direct-mapped,
// one-word-per-line write-back cache. The core path reads the primary tag
// copy and the snoop path reads a mirrored copy; both are written together.
// Assumes an external arbiter never grants while a peer drives snp_valid.
module msi_coh_ctrl #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_grant,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);
    import msi_pkg::*;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int NLINES = 1 << IDX_W;
    localparam int NCOPY  = 2;

    logic [IDX_W-1:0] cidx, sidx;
    logic [TAG_W-1:0] ctag, stag;
    logic [NLINES-1:0][1:0]       st_cp  [NCOPY];
    logic [NLINES-1:0][TAG_W-1:0] tag_cp [NCOPY];
    logic [NLINES-1:0][DATA_W-1:0] data_q;

    logic             blocked;
    logic             loc_need, loc_wb, loc_done, loc_upd, loc_fill, loc_wr;
    logic [1:0]       loc_cmd, loc_st;
    logic [TAG_W-1:0] loc_tag;
    logic             snp_upd;
    logic [1:0]       snp_st;

    // Split both addresses into tag and index; detect same-line conflicts.
    always_comb begin
        cidx    = cpu_addr[IDX_W-1:0];
        ctag    = cpu_addr[ADDR_W-1:IDX_W];
        sidx    = snp_addr[IDX_W-1:0];
        stag    = snp_addr[ADDR_W-1:IDX_W];
        blocked = snp_valid && (sidx == cidx);
    end

    // Primary (core) and duplicate (snoop) copies of state and tag.
    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        msi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
            .clk    (clk),
            .rst_n  (rst_n),
            .lw_en  (loc_upd),
            .lw_idx (cidx),
            .lw_st  (loc_st),
            .lw_tag (loc_tag),
            .sw_en  (snp_upd),
            .sw_idx (sidx),
            .sw_st  (snp_st),
            .st_q   (st_cp[k]),
            .tag_q  (tag_cp[k])
        );
    end

    msi_local_unit #(.TAG_W(TAG_W)) u_local (
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_tag   (ctag),
        .line_st   (st_cp[0][cidx]),
        .line_tag  (tag_cp[0][cidx]),
        .blocked   (blocked),
        .bus_grant (bus_grant),
        .bus_need  (loc_need),
        .bus_cmd   (loc_cmd),
        .wb_sel    (loc_wb),
        .done      (loc_done),
        .upd_en    (loc_upd),
        .upd_st    (loc_st),
        .upd_tag   (loc_tag),
        .fill_sel  (loc_fill),
        .wr_sel    (loc_wr)
    );

    msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_tag   (stag),
        .line_st   (st_cp[1][sidx]),
        .line_tag  (tag_cp[1][sidx]),
        .upd_en    (snp_upd),
        .upd_st    (snp_st),
        .supply    (snp_supply)
    );

    // Data words: written by a completing write or filled by a read miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (loc_done && loc_wr) begin
            data_q[cidx] <= cpu_wdata;
        end else if (loc_done && loc_fill) begin
            data_q[cidx] <= bus_rdata;
        end
    end

    // Drive the core and bus outputs.
    always_comb begin
        cpu_done  = loc_done;
        cpu_rdata = loc_fill ? bus_rdata : data_q[cidx];
        bus_req   = loc_need;
        bus_cmd   = loc_cmd;
        bus_addr  = loc_wb ? {tag_cp[0][cidx], cidx} : cpu_addr;
        bus_wdata = data_q[cidx];
        snp_data  = data_q[sidx];
    end

    // R11: the snoop copy mirrors the core copy at every edge.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r11_dup_mirror: assert (st_cp[0] == st_cp[1] && tag_cp[0] == tag_cp[1])
                else $error("snoop tag copy diverged");
        end
    end

    // R2: a completed access leaves the line valid with the request's tag.
    a_r2_done_leaves_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (st_cp[0][$past(cidx)] != ST_I) && (tag_cp[0][$past(cidx)] == $past(ctag)));

    // R4: a completed write leaves the line Modified.
    a_r4_write_owns_line: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_write) |=> (st_cp[0][$past(cidx)] == ST_M));

    // R7: after supplying data the line is no longer Modified.
    a_r7_supply_drops_owner: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> (st_cp[1][$past(sidx)] != ST_M));

    // R12: an ungranted request repeats unchanged while the core holds it.
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) ##1 (cpu_valid && $stable(cpu_addr) && $stable(cpu_write) && !blocked)
        |-> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
endmodule

// File: tb/sim_msi_coh_ctrl.sv
// Bench: bench-side model of line states and the shared level; directed
// cases plus a pseudo-random sweep of core requests and peer snoops.
module sim_msi_coh_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 0, cpu_write = 0;
    logic [5:0] cpu_addr = 0;
    logic [7:0] cpu_wdata = 0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic [1:0] bus_cmd;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       bus_grant = 0;
    logic [7:0] bus_rdata = 0;
    logic       snp_valid = 0;
    logic [1:0] snp_cmd = 0;
    logic [5:0] snp_addr = 0;
    logic       snp_supply;
    logic [7:0] snp_data;

    int n_cmp = 0, n_bad = 0;
    logic [1:0] m_st [4];
    logic [3:0] m_tag [4];
    logic [7:0] m_dat [4];
    logic [7:0] l2 [64];
    logic       c_v = 0, c_w = 0;
    logic [5:0] c_a = 0;
    logic [7:0] c_d = 0;
    logic       last_done = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    msi_coh_ctrl u0 (.*);

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // One cycle: drive, predict, grant, compare, update the model.
    task automatic step(input bit sv, input logic [1:0] sc, input logic [5:0] sa, input string rq);
        int si, ci;
        bit shit, esup, blk, go, chit, need, wb, edone, grant;
        logic [1:0] ecmd;
        logic [5:0] eaddr;
        logic [7:0] fill;
        @(negedge clk);
        snp_valid = sv; snp_cmd = sc; snp_addr = sa;
        cpu_valid = c_v; cpu_write = c_w; cpu_addr = c_a; cpu_wdata = c_d;
        bus_grant = 0;
        #2;
        si = int'(sa[1:0]); ci = int'(c_a[1:0]);
        shit = sv && m_st[si] != 2'd0 && m_tag[si] == sa[5:2];
        esup = shit && m_st[si] == 2'd2 && (sc == 2'd0 || sc == 2'd1);
        blk = sv && si == ci;
        go = c_v && !blk;
        chit = m_st[ci] != 2'd0 && m_tag[ci] == c_a[5:2];
        need = !(chit && (!c_w || m_st[ci] == 2'd2));
        wb = 0; ecmd = 2'd0;
        if (chit) ecmd = 2'd2;
        else if (m_st[ci] == 2'd2) begin ecmd = 2'd3; wb = 1; end
        else ecmd = c_w ? 2'd1 : 2'd0;
        eaddr = wb ? {m_tag[ci], c_a[1:0]} : c_a;
        grant = go && need && !sv;
        bus_grant = grant;
        bus_rdata = l2[eaddr];
        fill = l2[eaddr];
        edone = go && (!need || (grant && !wb));
        #2;
        chk(bus_req == (go && need), rq, "bus_req", int'(bus_req), int'(go && need));
        if (go && need) begin
            chk(bus_cmd == ecmd, rq, "bus_cmd", int'(bus_cmd), int'(ecmd));
            chk(bus_addr == eaddr, rq, "bus_addr", int'(bus_addr), int'(eaddr));
            if (wb) chk(bus_wdata == m_dat[ci], rq, "bus_wdata", int'(bus_wdata), int'(m_dat[ci]));
        end
        chk(snp_supply == esup, rq, "snp_supply", int'(snp_supply), int'(esup));
        if (esup) chk(snp_data == m_dat[si], rq, "snp_data", int'(snp_data), int'(m_dat[si]));
        chk(cpu_done == edone, rq, "cpu_done", int'(cpu_done), int'(edone));
        if (edone && !c_w) begin
            if (need) chk(cpu_rdata == fill, rq, "cpu_rdata fill", int'(cpu_rdata), int'(fill));
            else chk(cpu_rdata == m_dat[ci], rq, "cpu_rdata hit", int'(cpu_rdata), int'(m_dat[ci]));
        end
        if (esup) l2[sa] = m_dat[si];
        if (shit) begin
            if (sc == 2'd1 || sc == 2'd2) m_st[si] = 2'd0;
            else if (sc == 2'd0 && m_st[si] == 2'd2) m_st[si] = 2'd1;
        end
        if (grant && wb) begin
            l2[eaddr] = m_dat[ci];
            m_st[ci] = 2'd0;
        end else if (edone) begin
            if (c_w) begin m_st[ci] = 2'd2; m_tag[ci] = c_a[5:2]; m_dat[ci] = c_d; end
            else if (need) begin m_st[ci] = 2'd1; m_tag[ci] = c_a[5:2]; m_dat[ci] = fill; end
        end
        last_done = edone;
    endtask

    task automatic cpu_op(input bit w, input logic [5:0] a, input logic [7:0] d,
                          input bit sv, input logic [1:0] sc, input logic [5:0] sa, input string rq);
        c_v = 1; c_w = w; c_a = a; c_d = d;
        step(sv, sc, sa, rq);
        for (int i = 0; i < 6 && !last_done; i++) step(0, 2'd0, 6'd0, rq);
        if (!last_done) chk(0, rq, "completion", 0, 1);
        c_v = 0;
    endtask

    task automatic snoop_op(input logic [1:0] sc, input logic [5:0] sa, input string rq);
        c_v = 0;
        step(1, sc, sa, rq);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1 (run ended)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
        for (int i = 0; i < 64; i++) l2[i] = 8'((i * 37 + 11) % 256);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        step(0, 2'd0, 6'd0, "R1");
        // R1 R2: first read misses and fills Shared
        cpu_op(0, 6'd5, 8'h00, 0, 2'd0, 6'd0, "R2");
        // R3: read hit in Shared
        cpu_op(0, 6'd5, 8'h00, 0, 2'd0, 6'd0, "R3");
        // R4: write to Shared -> invalidate -> Modified
        cpu_op(1, 6'd5, 8'hA5, 0, 2'd0, 6'd0, "R4");
        // R5: write hit in Modified
        cpu_op(1, 6'd5, 8'h5A, 0, 2'd0, 6'd0, "R5");
        // R3: read hit in Modified
        cpu_op(0, 6'd5, 8'h00, 0, 2'd0, 6'd0, "R3");
        // R6: conflicting miss writes back the dirty line first
        cpu_op(0, 6'd9, 8'h00, 0, 2'd0, 6'd0, "R6");
        chk(l2[5] == 8'h5A, "R6", "written-back word", int'(l2[5]), 8'h5A);
        // R4: write miss from Invalid
        cpu_op(1, 6'd14, 8'h3C, 0, 2'd0, 6'd0, "R4");
        // R7: snooped read miss on Modified supplies and drops to Shared
        snoop_op(2'd0, 6'd14, "R7");
        cpu_op(1, 6'd14, 8'h77, 0, 2'd0, 6'd0, "R7");
        // R8: snooped write miss on Modified supplies and invalidates
        snoop_op(2'd1, 6'd14, "R8");
        cpu_op(0, 6'd14, 8'h00, 0, 2'd0, 6'd0, "R8");
        // R8: snooped invalidate on Shared
        snoop_op(2'd2, 6'd14, "R8");
        cpu_op(0, 6'd14, 8'h00, 0, 2'd0, 6'd0, "R8");
        // R9: ignored snoops
        cpu_op(1, 6'd3, 8'h99, 0, 2'd0, 6'd0, "R9");
        snoop_op(2'd1, 6'd7, "R9");
        snoop_op(2'd3, 6'd3, "R9");
        snoop_op(2'd0, 6'd14, "R9");
        cpu_op(1, 6'd3, 8'h98, 0, 2'd0, 6'd0, "R9");
        cpu_op(0, 6'd14, 8'h00, 0, 2'd0, 6'd0, "R9");
        // R10: same-index snoop blocks; pending invalidate turns into write miss
        c_v = 1; c_w = 1; c_a = 6'd14; c_d = 8'h42;
        step(1, 2'd2, 6'd14, "R10");
        chk(cpu_done == 0, "R10", "blocked done", int'(cpu_done), 0);
        step(0, 2'd0, 6'd0, "R10");
        chk(bus_cmd == 2'd1, "R10", "retry command", int'(bus_cmd), 1);
        c_v = 0;
        // R11: different-index snoop does not delay a hit
        c_v = 1; c_w = 0; c_a = 6'd14;
        step(1, 2'd0, 6'd3, "R11");
        chk(cpu_done == 1, "R11", "hit beside snoop", int'(cpu_done), 1);
        c_v = 0;
        // R12: ungranted request repeats
        c_v = 1; c_w = 0; c_a = 6'd13;
        step(1, 2'd0, 6'd0, "R12");
        chk(bus_req == 1 && cpu_done == 0, "R12", "held request", int'(bus_req), 1);
        step(0, 2'd0, 6'd0, "R12");
        chk(bus_cmd == 2'd0 && bus_addr == 6'd13, "R12", "repeated addr", int'(bus_addr), 13);
        c_v = 0;
        // Sweep: mixed requests and snoops, including same-cycle pairs
        for (int n = 0; n < 2500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[1:0])
                2'd0: cpu_op(lfsr[2], lfsr[8:3], lfsr[15:8], 0, 2'd0, 6'd0, "R4");
                2'd1: snoop_op(lfsr[3:2], lfsr[9:4], "R8");
                default: cpu_op(lfsr[2], lfsr[8:3], lfsr[15:8], 1, lfsr[11:10],
                                {lfsr[15:12], lfsr[4:3]}, "R10");
            endcase
        end
        step(0, 2'd0, 6'd0, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule